// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a processor register file organised as a ring of register windows that supports procedure calls. Each window has three groups of eight registers: incoming arguments, private locals, and outgoing arguments. The outgoing group of one window is the same storage as the incoming group of the next window in the ring. A caller writes arguments into its outgoing registers, advances the window, and the callee finds them in its incoming registers without any data being copied. A fixed bank of global registers sits outside the ring and is visible from every window.

Instructions name a register with a 5-bit logical index. The block translates that index to a physical register through the current window pointer. Call and return requests move the pointer. A saved window pointer marks the oldest window still held in the ring. A call that would wrap onto that window raises an overflow trap. A return onto it raises an underflow trap. In both cases the pointer stays where it is.

An external handler deals with the traps. It drains the oldest window through the spill port, or reloads the window below it through the fill port, then signals completion and retries the request. The handler, memory and pipeline are outside this block. Reset is synchronous and active-low.

Top module: `rwin_regfile`

## Requirements
- R1: While rst_n is low at a clock edge, the current and saved window pointers both become 0 and every register reads zero.
- R2: Logical indices map as follows: 0..7 are globals, 8..15 are incoming arguments, 16..23 are locals and 24..31 are outgoing arguments of the current window.
- R3: Logical index 0 always reads zero on both read ports, and writes to index 0 change nothing.
- R4: Outgoing register 24+j of window w is the same storage as incoming register 8+j of window (w+1) mod 8.
- R5: Globals 1..7 read the same value from every window.
- R6: Locals 16..23 are private to each window.
- R7: A call advances the current pointer by one (mod 8) when pointer+1 differs from the saved pointer. A return moves it back by one when it differs from the saved pointer. A call and a return together do nothing and raise no trap.
- R8: A call made while current+1 equals saved asserts overflow_trap combinationally in the same cycle and leaves the current pointer unchanged.
- R9: A return made while current equals saved asserts underflow_trap combinationally in the same cycle and leaves the current pointer unchanged.
- R10: spill_data shows register spill_idx of window saved_window, where 0..7 are its incoming and 8..15 its local registers. A spill_done pulse advances the saved pointer by one.
- R11: A fill_we write puts fill_data into register fill_idx of window saved_window-1 (mod 8), using the same 0..15 layout. A fill_done pulse moves the saved pointer back by one.
- R12: A read of the register being written through the write port in the same cycle returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_req | input | 1 | Procedure call: advance the window |
| ret_req | input | 1 | Procedure return: step the window back |
| rd_a_idx | input | 5 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical index to write |
| wr_data | input | 32 | Write data |
| overflow_trap | output | 1 | Call blocked: the ring is full |
| underflow_trap | output | 1 | Return blocked: the caller window is not resident |
| cur_window | output | 3 | Current window pointer |
| saved_window | output | 3 | Saved (oldest resident) window pointer |
| spill_idx | input | 4 | Register within the oldest window to drain |
| spill_data | output | 32 | Data of that register |
| spill_done | input | 1 | Pulse: oldest window drained |
| fill_we | input | 1 | Fill write enable |
| fill_idx | input | 4 | Register within the window being restored |
| fill_data | input | 32 | Data to restore |
| fill_done | input | 1 | Pulse: window restored |

## Verification
The hardest situation to reach is a ring that has wrapped. Here the saved pointer is not zero, the current pointer has passed window 7 back to 0, and a return must cross that boundary before it underflows onto a window that was spilled and then refilled. The bench fills every window with values built from the window and register numbers, and calls until it hits the overflow trap. It then spills window 0, retries the call so the pointer wraps, and returns all the way down to the underflow. Finally it refills window 0 with new values and checks that they appear in the restored caller, while the neighbouring window's data shows through the outgoing registers.

// File: rtl/rwin_pkg.sv
// Package: shared types of the register window file.
// Assumes every register group (globals, in, local, out) has the same size.
package rwin_pkg;
    // Upper two bits of a logical index select the register group.
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_IN     = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_OUT    = 2'd3
    } lgroup_e;
endpackage

// File: rtl/rwin_ptr_ctrl.sv
// Module: current/saved window pointer control.
// Moves the current pointer on calls and returns. Raises overflow or underflow
// traps instead of moving when the ring boundary is reached. Moves the saved
// pointer on spill and fill completion.
// Assumes NWIN is a power of two, so the pointers wrap by truncation.
module rwin_ptr_ctrl #(
    parameter int NWIN = 8,
    localparam int WW = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic          spill_done,
    input  logic          fill_done,
    output logic [WW-1:0] cwp,
    output logic [WW-1:0] swp,
    output logic          ovf,
    output logic          unf
);
    logic [WW-1:0] cwp_q, swp_q, cwp_inc;
    logic          ring_full, ring_empty, only_call, only_ret;

    // Boundary detection against the saved pointer.
    always_comb begin
        cwp_inc    = cwp_q + 1'b1;
        ring_full  = (cwp_inc == swp_q);
        ring_empty = (cwp_q == swp_q);
        only_call  = call_req & ~ret_req;
        only_ret   = ret_req & ~call_req;
        ovf        = only_call & ring_full;
        unf        = only_ret & ring_empty;
    end

    // Current pointer: step on an unblocked call or return.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cwp_q <= '0;
        else if (only_call && !ring_full)  cwp_q <= cwp_inc;
        else if (only_ret && !ring_empty)  cwp_q <= cwp_q - 1'b1;
    end

    // Saved pointer: forward after a spill, back after a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)                         swp_q <= '0;
        else if (spill_done && !fill_done)  swp_q <= swp_q + 1'b1;
        else if (fill_done && !spill_done)  swp_q <= swp_q - 1'b1;
    end

    assign cwp = cwp_q;
    assign swp = swp_q;
endmodule

// File: rtl/rwin_addr_map.sv
// Module: logical-to-physical register index translation.
// Physical layout: globals first, then 2*NGRP registers per window
// (incoming group, then locals). A window's outgoing group is the
// incoming group of the next window in the ring.
// Assumes NGRP and NWIN are powers of two.
module rwin_addr_map
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int NGRP = 8,
    localparam int WW   = $clog2(NWIN),
    localparam int OW   = $clog2(NGRP),
    localparam int LW   = OW + 2,
    localparam int WSZ  = 2 * NGRP,
    localparam int PHYS = NGRP + NWIN * WSZ,
    localparam int PW   = $clog2(PHYS)
) (
    input  logic [WW-1:0] win,
    input  logic [LW-1:0] lidx,
    output logic [PW-1:0] pidx
);
    lgroup_e       grp;
    logic [OW-1:0] off;
    logic [WW-1:0] win_nxt;
    logic [PW-1:0] base_cur, base_nxt;

    // Decode the group and compute both candidate window bases.
    always_comb begin
        grp      = lgroup_e'(lidx[LW-1 -: 2]);
        off      = lidx[OW-1:0];
        win_nxt  = win + 1'b1;
        base_cur = PW'(NGRP) + PW'(win) * PW'(WSZ);
        base_nxt = PW'(NGRP) + PW'(win_nxt) * PW'(WSZ);
        unique case (grp)
            GRP_GLOBAL: pidx = PW'(off);
            GRP_IN:     pidx = base_cur + PW'(off);
            GRP_LOCAL:  pidx = base_cur + PW'(NGRP) + PW'(off);
            default:    pidx = base_nxt + PW'(off);
        endcase
    end
endmodule

// File: rtl/rwin_storage.sv
// Module: flat physical register array.
// Two synchronous write ports (port B wins on a collision) and NRD
// combinational read ports. Cleared on reset.
module rwin_storage #(
    parameter int PHYS = 136,
    parameter int DW   = 32,
    parameter int NRD  = 3,
    localparam int PW  = $clog2(PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [PW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [PW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic [PW-1:0] rd_addr [NRD],
    output logic [DW-1:0] rd_data [NRD]
);
    logic [DW-1:0] mem [PHYS];

    // Register update: reset clear, then the instruction write, then the fill write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) mem[i] <= '0;
        end else begin
            if (wa_en) mem[wa_addr] <= wa_data;
            if (wb_en) mem[wb_addr] <= wb_data;
        end
    end

    // One combinational read mux per read port.
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = mem[rd_addr[r]];
    end
endmodule

// File: rtl/rwin_regfile.sv
// Module: overlapping register window file (top).
// Two bypassed read ports and one write port, all addressed through the
// current window. A spill read port and a fill write port are addressed
// through the saved window. Index 0 is a constant zero.
// Assumes the trap handler stalls instruction traffic while it spills or fills.
module rwin_regfile #(
    parameter int NWIN = 8,
    parameter int NGRP = 8,
    parameter int DW   = 32,
    localparam int WW   = $clog2(NWIN),
    localparam int OW   = $clog2(NGRP),
    localparam int LW   = OW + 2,
    localparam int SW   = OW + 1,
    localparam int WSZ  = 2 * NGRP,
    localparam int PHYS = NGRP + NWIN * WSZ,
    localparam int PW   = $clog2(PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic [LW-1:0] rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [LW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic          overflow_trap,
    output logic          underflow_trap,
    output logic [WW-1:0] cur_window,
    output logic [WW-1:0] saved_window,
    input  logic [SW-1:0] spill_idx,
    output logic [DW-1:0] spill_data,
    input  logic          spill_done,
    input  logic          fill_we,
    input  logic [SW-1:0] fill_idx,
    input  logic [DW-1:0] fill_data,
    input  logic          fill_done
);
    localparam int NMAP = 3;  // read A, read B, write

    logic [WW-1:0] cwp, swp, fill_win;
    logic [LW-1:0] lidx [NMAP];
    logic [PW-1:0] pidx [NMAP];
    logic [PW-1:0] rd_addr [3];
    logic [DW-1:0] rd_raw [3];
    logic [PW-1:0] spill_p, fill_p;
    logic          wr_live;

    rwin_ptr_ctrl #(.NWIN(NWIN)) u_ptr (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
        .spill_done(spill_done), .fill_done(fill_done),
        .cwp(cwp), .swp(swp), .ovf(overflow_trap), .unf(underflow_trap)
    );

    assign lidx[0] = rd_a_idx;
    assign lidx[1] = rd_b_idx;
    assign lidx[2] = wr_idx;

    // One translator per window-relative access.
    for (genvar m = 0; m < NMAP; m++) begin : g_map
        rwin_addr_map #(.NWIN(NWIN), .NGRP(NGRP)) u_map (
            .win(cwp), .lidx(lidx[m]), .pidx(pidx[m])
        );
    end

    // Physical addresses of the spill and fill ports (oldest window and the one below it).
    always_comb begin
        fill_win = swp - 1'b1;
        spill_p  = PW'(NGRP) + PW'(swp) * PW'(WSZ) + PW'(spill_idx);
        fill_p   = PW'(NGRP) + PW'(fill_win) * PW'(WSZ) + PW'(fill_idx);
        wr_live  = wr_en && (wr_idx != '0);
    end

    assign rd_addr[0] = pidx[0];
    assign rd_addr[1] = pidx[1];
    assign rd_addr[2] = spill_p;

    rwin_storage #(.PHYS(PHYS), .DW(DW), .NRD(3)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wr_live), .wa_addr(pidx[2]), .wa_data(wr_data),
        .wb_en(fill_we), .wb_addr(fill_p), .wb_data(fill_data),
        .rd_addr(rd_addr), .rd_data(rd_raw)
    );

    // Read ports: constant zero at index 0, otherwise bypass a same-cycle write.
    always_comb begin
        if (rd_a_idx == '0)                     rd_a_data = '0;
        else if (wr_live && wr_idx == rd_a_idx) rd_a_data = wr_data;
        else                                    rd_a_data = rd_raw[0];
        if (rd_b_idx == '0)                     rd_b_data = '0;
        else if (wr_live && wr_idx == rd_b_idx) rd_b_data = wr_data;
        else                                    rd_b_data = rd_raw[1];
    end

    assign spill_data   = rd_raw[2];
    assign cur_window   = cwp;
    assign saved_window = swp;
endmodule

// File: rtl/rwin_regfile_chk.sv
// Module: property checker for rwin_regfile, attached by bind.
// Observes ports only.
module rwin_regfile_chk #(
    parameter int WW = 3,
    parameter int LW = 5,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          call_req,
    input logic          ret_req,
    input logic [LW-1:0] rd_a_idx,
    input logic [DW-1:0] rd_a_data,
    input logic [LW-1:0] rd_b_idx,
    input logic [DW-1:0] rd_b_data,
    input logic          wr_en,
    input logic [LW-1:0] wr_idx,
    input logic [DW-1:0] wr_data,
    input logic          overflow_trap,
    input logic          underflow_trap,
    input logic [WW-1:0] cur_window,
    input logic [WW-1:0] saved_window,
    input logic          spill_done,
    input logic          fill_done
);
    a_r3_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == '0) |-> (rd_a_data == '0 && (rd_b_idx != '0 || rd_b_data == '0)));

    a_r7_call_step: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !ret_req && !overflow_trap) |=> cur_window == WW'($past(cur_window) + 1'b1));

    a_r7_ret_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req && !underflow_trap) |=> cur_window == WW'($past(cur_window) - 1'b1));

    a_r7_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && ret_req) |-> (!overflow_trap && !underflow_trap) ##1 $stable(cur_window));

    a_r8_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_trap |-> (call_req && WW'(cur_window + 1'b1) == saved_window) ##1 $stable(cur_window));

    a_r9_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_trap |-> (ret_req && cur_window == saved_window) ##1 $stable(cur_window));

    a_r10_spill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_done && !fill_done) |=> saved_window == WW'($past(saved_window) + 1'b1));

    a_r11_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && !spill_done) |=> saved_window == WW'($past(saved_window) - 1'b1));

    a_r12_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0 && rd_a_idx == wr_idx) |-> rd_a_data == wr_data);
endmodule

bind rwin_regfile rwin_regfile_chk #(.WW(WW), .LW(LW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .overflow_trap(overflow_trap), .underflow_trap(underflow_trap),
    .cur_window(cur_window), .saved_window(saved_window),
    .spill_done(spill_done), .fill_done(fill_done)
);

// File: tb/rwin_regfile_test.sv
// Bench: sweeps every window and every logical index, walks the ring through
// overflow, spill, wrap, underflow and fill. Expected values are arithmetic.
module rwin_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 0, ret_req = 0, wr_en = 0;
    logic        spill_done = 0, fill_we = 0, fill_done = 0;
    logic [4:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
    logic [31:0] wr_data = 0, fill_data = 0;
    logic [3:0]  spill_idx = 0, fill_idx = 0;
    logic [31:0] rd_a_data, rd_b_data, spill_data;
    logic        overflow_trap, underflow_trap;
    logic [2:0]  cur_window, saved_window;
    int n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    rwin_regfile uut (.*);

    function automatic logic [31:0] vwin(input int w, input int l);
        return 32'h5A00_0000 | (w << 8) | l;
    endfunction
    function automatic logic [31:0] vglob(input int j);
        return 32'hC0DE_0000 | j;
    endfunction
    function automatic logic [31:0] vfill(input int k);
        return 32'hF111_0000 | k;
    endfunction
    // Expected content after the window sweep (R2, R4, R5, R6).
    function automatic logic [31:0] exp_sweep(input int w, input int l);
        if (l == 0)  return 32'h0;
        if (l < 8)   return vglob(l);
        if (l < 24)  return vwin(w, l);
        return vwin((w + 1) % 8, l - 16);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask
    task automatic step();
        @(posedge clk); #1;
    endtask
    task automatic wr(input int idx, input logic [31:0] d);
        wr_en = 1; wr_idx = 5'(idx); wr_data = d; step(); wr_en = 0;
    endtask
    task automatic rd_pair(input int idx, input logic [31:0] exp, input string req);
        rd_a_idx = 5'(idx); rd_b_idx = 5'(idx); #1;
        chk(req, rd_a_data, exp); chk(req, rd_b_data, exp);
    endtask
    task automatic do_call(input logic trap, input int exp_cwp, input string req);
        call_req = 1; #1; chk(req, {31'b0, overflow_trap}, {31'b0, trap});
        step(); call_req = 0; chk(req, {29'b0, cur_window}, 32'(exp_cwp));
    endtask
    task automatic do_ret(input logic trap, input int exp_cwp, input string req);
        ret_req = 1; #1; chk(req, {31'b0, underflow_trap}, {31'b0, trap});
        step(); ret_req = 0; chk(req, {29'b0, cur_window}, 32'(exp_cwp));
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        step(); step(); step();
        // R1: reset state
        chk("R1", {29'b0, cur_window}, 0);
        chk("R1", {29'b0, saved_window}, 0);
        for (int l = 0; l < 32; l++) rd_pair(l, 0, "R1");
        rst_n = 1; step();

        // R3: writes to index 0 ignored, reads zero, even while bypassing
        for (int j = 1; j < 8; j++) wr(j, vglob(j));
        wr_en = 1; wr_idx = 0; wr_data = 32'hDEAD_BEEF; rd_a_idx = 0; rd_b_idx = 0; #1;
        chk("R3", rd_a_data, 0); chk("R3", rd_b_data, 0);
        step(); wr_en = 0;
        rd_pair(0, 0, "R3");

        // Populate in+local registers of all eight windows (R7 call stepping)
        for (int w = 0; w < 8; w++) begin
            for (int l = 8; l < 24; l++) wr(l, vwin(w, l));
            if (w < 7) do_call(1'b0, w + 1, "R7");
        end
        // R8: ring full
        do_call(1'b1, 7, "R8");

        // Sweep down: mapping, overlap, globals, locals
        for (int w = 7; w >= 0; w--) begin
            for (int l = 0; l < 32; l++)
                rd_pair(l, exp_sweep(w, l), l < 8 ? "R5" : l < 16 ? "R2" : l < 24 ? "R6" : "R4");
            if (w > 0) do_ret(1'b0, w - 1, "R7");
        end
        // R9: empty ring
        do_ret(1'b1, 0, "R9");
        // R7: call and return together
        call_req = 1; ret_req = 1; #1;
        chk("R7", {30'b0, overflow_trap, underflow_trap}, 0);
        step(); call_req = 0; ret_req = 0;
        chk("R7", {29'b0, cur_window}, 0);

        // R12: same-cycle bypass, then the value persists
        wr_en = 1; wr_idx = 17; wr_data = 32'h1234_5678; rd_a_idx = 17; rd_b_idx = 17; #1;
        chk("R12", rd_a_data, 32'h1234_5678); chk("R12", rd_b_data, 32'h1234_5678);
        step(); wr_en = 0;
        rd_pair(17, 32'h1234_5678, "R12");
        wr(17, vwin(0, 17));

        // Climb to overflow, spill window 0, retry to wrap
        for (int w = 1; w < 8; w++) do_call(1'b0, w, "R7");
        do_call(1'b1, 7, "R8");
        for (int k = 0; k < 16; k++) begin
            spill_idx = 4'(k); #1;
            chk("R10", spill_data, vwin(0, 8 + k));
        end
        spill_done = 1; step(); spill_done = 0;
        chk("R10", {29'b0, saved_window}, 1);
        do_call(1'b0, 0, "R8");

        // Return across the wrap down to window 1, then underflow
        do_ret(1'b0, 7, "R7");
        for (int w = 6; w >= 1; w--) do_ret(1'b0, w, "R7");
        do_ret(1'b1, 1, "R9");
        for (int k = 0; k < 16; k++) begin
            fill_we = 1; fill_idx = 4'(k); fill_data = vfill(k); step();
        end
        fill_we = 0;
        fill_done = 1; step(); fill_done = 0;
        chk("R11", {29'b0, saved_window}, 0);
        do_ret(1'b0, 0, "R11");
        for (int l = 8; l < 24; l++) rd_pair(l, vfill(l - 8), "R11");
        for (int l = 24; l < 32; l++) rd_pair(l, vwin(1, l - 16), "R4");

        // R1: reset during operation
        do_call(1'b0, 1, "R7");
        rst_n = 0; step(); rst_n = 1;
        chk("R1", {29'b0, cur_window}, 0);
        chk("R1", {29'b0, saved_window}, 0);
        rd_pair(9, 0, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule